// File: doc/BRIEF.md
# Serial Encoder Control Channel Sequencer

This block runs the slow control channel of a clocked serial position-encoder link. The control channel carries one bit per position cycle in each direction: a host-to-encoder bit (CDM) that the frame engine sends during the cycle's timeout phase, and an encoder-to-host bit (CDS) that the frame receiver captures from the position frame. A register read therefore spans dozens of position cycles. The sequencer owns that slow exchange. It decides which CDM bit goes out in each cycle and collects each returned CDS bit. Position decoding and line timing stay with the frame receiver.

A 16-bit command word, loaded with a one-clock strobe while the block is idle, starts a sequence. The sequence has seven parts:

1. Fourteen zero CDM bits, which reset the encoder's control logic.
2. A CDM start bit of 1.
3. The 16 command bits, MSB first.
4. The inverted CRC-4 of those command bits.
5. One cycle that expects the encoder's start bit on CDS.
6. Eight returned data bits.
7. The inverted CRC-4 of the returned data.

The frame receiver pulses `cyc_i` once per completed position cycle. The CDM value that is present at that pulse is the bit consumed for the cycle, and `cds_i` carries the captured bit. When the sequence ends, the block raises either a done flag with the read byte or an error flag, and returns CDM to a steady 1.

Top module: `ctl_seq_top`

## Requirements
- R1: After reset, `busy_o`=0, `done_o`=0, `err_o`=0, `cdm_o`=1 and `rdata_o`=0.
- R2: A command strobe is accepted only while `busy_o` is 0; `busy_o` rises on the next clock. A strobe while busy has no effect on the CDM stream or on the result.
- R3: The sequence advances by exactly one bit per `cyc_i` pulse; between pulses `cdm_o` and `busy_o` hold.
- R4: The first 14 strobes of a sequence see `cdm_o`=0; the 15th sees `cdm_o`=1 (start bit).
- R5: Strobes 16 to 31 see the command word on `cdm_o`, bit 15 first.
- R6: Strobes 32 to 35 see the bitwise inverse of the CRC-4 of the 16 command bits, MSB first. The CRC uses polynomial x^4+x+1 and initial value 0, and each bit is fed in MSB first as feedback = crc[3] xor bit.
- R7: At strobe 36, `cds_i` must be 1 (encoder start bit). If it is 0, the sequence ends at that strobe with `err_o`=1 and `done_o`=0.
- R8: Strobes 37 to 44 shift `cds_i` into `rdata_o`, MSB first. From strobe 36 through the end of the sequence, `cdm_o` is 0.
- R9: At strobes 45 to 48, `cds_i` is compared with the inverse of the CRC-4 (same rule as R6) of the 8 data bits, MSB first. After strobe 48, `done_o`=1 if all four bits match; otherwise `err_o`=1.
- R10: When a sequence ends, `busy_o` falls and `cdm_o` returns to 1. `done_o`, `err_o` and `rdata_o` hold until the next accepted command, which clears all three.
- R11: If a command strobe and `cyc_i` fall in the same clock while idle, the command is accepted and that `cyc_i` is not counted as a bit. If a command strobe falls in the same clock as the final strobe of a sequence, the command is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cmd_valid_i | input | 1 | Command strobe, one clock |
| cmd_word_i | input | 16 | Command word |
| cyc_i | input | 1 | One pulse per completed position cycle |
| cds_i | input | 1 | CDS bit captured in that cycle |
| cdm_o | output | 1 | CDM bit for the current cycle |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | Sequence finished with valid data |
| err_o | output | 1 | Sequence failed (no start bit or CRC mismatch) |
| rdata_o | output | 8 | Returned register byte |

## Verification
Two functions can collide in one clock: accepting a command, and advancing on a position-cycle strobe. The bench provokes this in two places. It raises the command strobe together with `cyc_i` while the block is idle, and it raises it together with the final strobe of a running sequence. In the first case it judges the collision by checking that a full 48-bit CDM stream follows, with no bit lost. In the second case it checks that the block ends idle with the old result and does not restart. Command strobes in the gaps between position strobes of a running sequence are judged the same way, against a reference stream built from the first command.

// File: rtl/ctl_seq_pkg.sv
package ctl_seq_pkg;
  typedef enum logic [2:0] {
    PH_IDLE, PH_ZERO, PH_START, PH_CMD, PH_CTX, PH_ESYNC, PH_DATA, PH_CRX
  } phase_e;

  localparam int CRC_W = 4;

  // x^4+x+1, MSB-first serial update
  function automatic logic [CRC_W-1:0] crc4_step(logic [CRC_W-1:0] c, logic b);
    logic fb;
    fb = c[CRC_W-1] ^ b;
    return {c[CRC_W-2:0], 1'b0} ^ (fb ? 4'b0011 : 4'b0000);
  endfunction
endpackage

// File: rtl/ctl_crc4.sv
module ctl_crc4
  import ctl_seq_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic step_i,
  input  logic shift_i,
  input  logic bit_i,
  output logic msb_o
);
  logic [CRC_W-1:0] crc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      crc_q <= '0;
    else if (clr_i)   crc_q <= '0;
    else if (step_i)  crc_q <= crc4_step(crc_q, bit_i);
    else if (shift_i) crc_q <= {crc_q[CRC_W-2:0], 1'b0};
  end

  assign msb_o = crc_q[CRC_W-1];
endmodule

// File: rtl/ctl_seq_fsm.sv
module ctl_seq_fsm
  import ctl_seq_pkg::*;
#(
  parameter int ZERO_RUN = 14,
  parameter int CMD_W    = 16,
  parameter int DATA_W   = 8
) (
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   start_i,
  input  logic   adv_i,
  input  logic   abort_i,
  output phase_e phase_o,
  output logic   last_o
);
  localparam int MAX_LEN = (ZERO_RUN > CMD_W) ?
                           ((ZERO_RUN > DATA_W) ? ZERO_RUN : DATA_W) :
                           ((CMD_W > DATA_W) ? CMD_W : DATA_W);
  localparam int CNT_W = $clog2(MAX_LEN + 1);

  phase_e           ph_q, ph_nx;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] len;

  always_comb begin
    unique case (ph_q)
      PH_ZERO:  len = CNT_W'(ZERO_RUN);
      PH_CMD:   len = CNT_W'(CMD_W);
      PH_CTX:   len = CNT_W'(CRC_W);
      PH_DATA:  len = CNT_W'(DATA_W);
      PH_CRX:   len = CNT_W'(CRC_W);
      default:  len = CNT_W'(1);
    endcase
  end

  assign last_o = (cnt_q == len - CNT_W'(1));

  always_comb begin
    unique case (ph_q)
      PH_ZERO:  ph_nx = PH_START;
      PH_START: ph_nx = PH_CMD;
      PH_CMD:   ph_nx = PH_CTX;
      PH_CTX:   ph_nx = PH_ESYNC;
      PH_ESYNC: ph_nx = PH_DATA;
      PH_DATA:  ph_nx = PH_CRX;
      default:  ph_nx = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q  <= PH_IDLE;
      cnt_q <= '0;
    end else if (ph_q == PH_IDLE) begin
      if (start_i) begin
        ph_q  <= PH_ZERO;
        cnt_q <= '0;
      end
    end else if (adv_i) begin
      if (abort_i) begin
        ph_q  <= PH_IDLE;
        cnt_q <= '0;
      end else if (last_o) begin
        ph_q  <= ph_nx;
        cnt_q <= '0;
      end else begin
        cnt_q <= cnt_q + CNT_W'(1);
      end
    end
  end

  assign phase_o = ph_q;
endmodule

// File: rtl/ctl_seq_top.sv
module ctl_seq_top
  import ctl_seq_pkg::*;
#(
  parameter int ZERO_RUN = 14,
  parameter int CMD_W    = 16,
  parameter int DATA_W   = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_valid_i,
  input  logic [CMD_W-1:0]  cmd_word_i,
  input  logic              cyc_i,
  input  logic              cds_i,
  output logic              cdm_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              err_o,
  output logic [DATA_W-1:0] rdata_o
);
  phase_e              phase;
  logic                last, idle, accept, adv, abort;
  logic                tx_msb, rx_msb, crc_bad, mism_q;
  logic [CMD_W-1:0]    cmd_q;
  logic [DATA_W-1:0]   rdata_q;
  logic                done_q, err_q;

  assign idle   = (phase == PH_IDLE);
  assign accept = cmd_valid_i && idle;
  assign adv    = cyc_i && !idle;
  assign abort  = (phase == PH_ESYNC) && !cds_i;

  ctl_seq_fsm #(.ZERO_RUN(ZERO_RUN), .CMD_W(CMD_W), .DATA_W(DATA_W)) u_fsm (
    .clk_i, .rst_ni,
    .start_i (accept),
    .adv_i   (adv),
    .abort_i (abort),
    .phase_o (phase),
    .last_o  (last)
  );

  ctl_crc4 u_tx_crc (
    .clk_i, .rst_ni,
    .clr_i   (accept),
    .step_i  (adv && phase == PH_CMD),
    .shift_i (adv && phase == PH_CTX),
    .bit_i   (cmd_q[CMD_W-1]),
    .msb_o   (tx_msb)
  );

  ctl_crc4 u_rx_crc (
    .clk_i, .rst_ni,
    .clr_i   (accept),
    .step_i  (adv && phase == PH_DATA),
    .shift_i (adv && phase == PH_CRX),
    .bit_i   (cds_i),
    .msb_o   (rx_msb)
  );

  assign crc_bad = (phase == PH_CRX) && (cds_i != !rx_msb);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_q   <= '0;
      rdata_q <= '0;
      mism_q  <= 1'b0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else if (accept) begin
      cmd_q   <= cmd_word_i;
      rdata_q <= '0;
      mism_q  <= 1'b0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else if (adv) begin
      if (phase == PH_CMD)  cmd_q   <= {cmd_q[CMD_W-2:0], 1'b0};
      if (phase == PH_DATA) rdata_q <= {rdata_q[DATA_W-2:0], cds_i};
      if (crc_bad)          mism_q  <= 1'b1;
      if (abort)            err_q   <= 1'b1;
      if (phase == PH_CRX && last) begin
        if (mism_q || crc_bad) err_q  <= 1'b1;
        else                   done_q <= 1'b1;
      end
    end
  end

  always_comb begin
    unique case (phase)
      PH_IDLE:  cdm_o = 1'b1;
      PH_START: cdm_o = 1'b1;
      PH_CMD:   cdm_o = cmd_q[CMD_W-1];
      PH_CTX:   cdm_o = !tx_msb;
      default:  cdm_o = 1'b0;
    endcase
  end

  assign busy_o  = !idle;
  assign done_o  = done_q;
  assign err_o   = err_q;
  assign rdata_o = rdata_q;
endmodule

// File: rtl/ctl_seq_chk.sv
module ctl_seq_chk #(
  parameter int ZERO_RUN = 14,
  parameter int DATA_W   = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cmd_valid_i,
  input logic              cyc_i,
  input logic              cdm_o,
  input logic              busy_o,
  input logic              done_o,
  input logic              err_o,
  input logic [DATA_W-1:0] rdata_o
);
  logic [7:0] zcnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   zcnt_q <= '0;
    else if (cmd_valid_i && !busy_o) zcnt_q <= '0;
    else if (cyc_i && busy_o && zcnt_q != 8'hff) zcnt_q <= zcnt_q + 8'd1;
  end

  a_r10_idle_cdm_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> cdm_o);

  a_r9_flags_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_o && err_o));

  a_r10_busy_clears_flags: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> (!done_o && !err_o));

  a_r3_hold_between_strobes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !cyc_i) |=> (busy_o && $stable(cdm_o)));

  a_r4_zero_run: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && zcnt_q < 8'(ZERO_RUN)) |-> !cdm_o);

  a_r3_end_on_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> $past(cyc_i));

  a_r10_result_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !cmd_valid_i) |=> (done_o && $stable(rdata_o)));
endmodule

bind ctl_seq_top ctl_seq_chk #(.ZERO_RUN(ZERO_RUN), .DATA_W(DATA_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cmd_valid_i (cmd_valid_i),
  .cyc_i       (cyc_i),
  .cdm_o       (cdm_o),
  .busy_o      (busy_o),
  .done_o      (done_o),
  .err_o       (err_o),
  .rdata_o     (rdata_o)
);

// File: tb/sim_ctl_seq_top.sv
module sim_ctl_seq_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cmd_valid_i = 1'b0;
  logic [15:0] cmd_word_i = '0;
  logic        cyc_i = 1'b0;
  logic        cds_i = 1'b0;
  logic        cdm_o, busy_o, done_o, err_o;
  logic [7:0]  rdata_o;

  int total = 0;
  int bad   = 0;
  bit ended = 0;

  always #2 clk_i = ~clk_i;

  ctl_seq_top u0 (.*);

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [3:0] ref_crc(input logic [31:0] v, input int n);
    logic [3:0] c = 4'h0;
    for (int k = n - 1; k >= 0; k--) begin
      logic fb = c[3] ^ v[k];
      c = {c[2:0], 1'b0};
      if (fb) c = c ^ 4'b0011;
    end
    return c;
  endfunction

  task automatic run_seq(input logic [15:0] cmd, input logic [7:0] data,
                         input bit bad_sync, input bit bad_crc,
                         input bit col_start, input bit col_end, input bit busy_cmd);
    logic [3:0] tc = ~ref_crc({16'h0, cmd}, 16);
    logic [3:0] rc = ~ref_crc({24'h0, data}, 8);
    int n = bad_sync ? 36 : 48;
    int zb = 0, cb = 0, tb = 0, qb = 0;
    @(negedge clk_i);
    cmd_valid_i = 1'b1; cmd_word_i = cmd; cyc_i = col_start;
    @(negedge clk_i);
    cmd_valid_i = 1'b0; cyc_i = 1'b0;
    chk(busy_o && !done_o && !err_o, "R2 accept", {busy_o, done_o, err_o}, 3'b100);
    for (int i = 0; i < n; i++) begin
      logic e, d;
      int gap = $urandom_range(0, 2);
      for (int g = 0; g < gap; g++) @(negedge clk_i);
      if (busy_cmd && i == 20) begin
        cmd_valid_i = 1'b1; cmd_word_i = ~cmd;
        @(negedge clk_i);
        cmd_valid_i = 1'b0;
      end
      if (i < 14)      e = 1'b0;
      else if (i == 14) e = 1'b1;
      else if (i < 31) e = cmd[30 - i];
      else if (i < 35) e = tc[34 - i];
      else             e = 1'b0;
      if (cdm_o !== e) begin
        if (i < 15) zb++; else if (i < 31) cb++; else if (i < 35) tb++; else qb++;
      end
      if (i == 35)      d = !bad_sync;
      else if (i < 35)  d = $urandom_range(0, 1);
      else if (i < 44)  d = data[43 - i];
      else              d = rc[47 - i] ^ (bad_crc && i == 45);
      cds_i = d; cyc_i = 1'b1;
      if (col_end && i == n - 1) begin
        cmd_valid_i = 1'b1; cmd_word_i = 16'h1234;
      end
      @(negedge clk_i);
      cyc_i = 1'b0; cmd_valid_i = 1'b0;
    end
    chk(zb == 0, "R4 zero run and start bit", zb, 0);
    chk(cb == 0, "R5 command bits", cb, 0);
    chk(tb == 0, "R6 command crc", tb, 0);
    chk(qb == 0, "R8 cdm low in return part", qb, 0);
    chk(!busy_o && cdm_o, "R10 idle after end", {busy_o, cdm_o}, 2'b01);
    if (bad_sync)
      chk(err_o && !done_o, "R7 missing start bit", {done_o, err_o}, 2'b01);
    else if (bad_crc)
      chk(err_o && !done_o, "R9 crc mismatch", {done_o, err_o}, 2'b01);
    else begin
      chk(done_o && !err_o, "R9 crc ok done", {done_o, err_o}, 2'b10);
      chk(rdata_o == data, "R8 read byte", rdata_o, data);
    end
    repeat (3) @(negedge clk_i);
    chk(!busy_o && (done_o || err_o), "R10 result held", {busy_o, done_o, err_o}, {1'b0, !bad_sync && !bad_crc, bad_sync || bad_crc});
  endtask

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(!busy_o && !done_o && !err_o && cdm_o && rdata_o == 8'h0, "R1 reset state",
        {busy_o, done_o, err_o, cdm_o, rdata_o}, 12'h100);
    run_seq(16'hA5C3, 8'h5A, 0, 0, 0, 0, 0);
    run_seq(16'h0001, 8'hFF, 0, 0, 1, 0, 0);  // R11 collision at start
    run_seq(16'hFFFF, 8'h00, 0, 0, 0, 1, 0);  // R11 collision at end
    chk(!busy_o, "R11 end-collision command ignored", busy_o, 0);
    run_seq(16'h3C3C, 8'h81, 0, 0, 0, 0, 1);  // R2 strobe while busy ignored
    run_seq(16'h8000, 8'h42, 1, 0, 0, 0, 0);  // R7
    run_seq(16'h7E01, 8'hC9, 0, 1, 0, 0, 0);  // R9
    for (int r = 0; r < 6; r++)
      run_seq(16'($urandom), 8'($urandom), 0, ($urandom_range(0, 3) == 0), r[0], 0, r[1]);
    // R3: no strobe, nothing moves
    @(negedge clk_i); cmd_valid_i = 1'b1; cmd_word_i = 16'hFFFF;
    @(negedge clk_i); cmd_valid_i = 1'b0;
    repeat (10) @(negedge clk_i);
    chk(busy_o && !cdm_o, "R3 hold without strobe", {busy_o, cdm_o}, 2'b10);
    ended = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!ended) begin
      total++; bad++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule